// File: doc/BRIEF.md
# Nibble-Serial Segment Data Receiver

This block is the digital front end of a 124-segment driver for a bistable display. A host sends segment data four bits at a time over a small serial link made up of an active-low select, a shift clock and a 4-bit data bus. Inside the block the nibbles are collected in a 124-bit shift register. When the host releases the select line, the collected bits are copied into an output latch. A separate output-enable input decides whether the latched bits are driven onto the 124 segment pins or whether every pin is left floating. Each pin's drive-enable is brought out so that the three-state pad cells can sit outside this block.

Every nibble enters at the top of the shift register and pushes the older contents down by four bits. In a complete frame of 31 nibbles, the first nibble sent ends at segments 3:0 and the last one at segments 123:120. A host that only needs to refresh the top segments can send fewer nibbles and then release the select line. The lower segments then hold whatever was shifted down into them.

The whole block runs on one system clock. Each link input passes through a two-stage synchronizer. Edges on the link are found by comparing the synchronized value with its previous value, so the system clock must run several times faster than the link clock. A power-control input puts the logic in standby. In standby, shifting and latching stop and all pins float.

Top module: `seg_link_rx`

## Requirements
- R1: A shift-clock falling edge moves the data bus into the shift register only while select is low; shift-clock edges while select is high leave the register unchanged.
- R2: Each accepted nibble is placed in bits 123:120 of the shift register, and the older contents move four positions toward bit 0.
- R3: After a full 31-nibble frame and release of select, segment bits 3:0 hold the first nibble and bits 123:120 hold the last.
- R4: The output latch (`seg_data`) is loaded from the shift register only when select rises; it does not change at any other time.
- R5: After a partial transfer of N nibbles, the top 4·N latched bits hold those nibbles in order (the last one at 123:120), and the lower bits hold the previous contents moved down by 4·N.
- R6: While the output enable is high and the logic is active, all 124 bits of `seg_drive` are 1 and each pin carries its latched bit; while the output enable is low, all bits of `seg_drive` are 0 (high impedance).
- R7: While `logic_on` is low, shifting and latching are blocked, the latch keeps its value, and `seg_drive` is all zero from the first clock edge at which `logic_on` is seen low.
- R8: Synchronous reset clears the shift register and the latch to zero and sets `seg_drive` to all zero.
- R9: A change on a link input or on the output enable takes effect at the third rising system-clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| logic_on | input | 1 | 1 = logic active, 0 = standby |
| link_sel_n | input | 1 | Link select, active low |
| link_sclk | input | 1 | Link shift clock; data is taken on its falling edge |
| link_nib | input | 4 | Link data nibble |
| drv_en | input | 1 | Output enable for the segment pins |
| seg_data | output | 124 | Latched segment levels (1 = high, 0 = low) |
| seg_drive | output | 124 | Per-pin drive enable (0 = high impedance) |

## Verification
A shift-clock fall, a select rise or an output-enable change made just before rising edge E0 shows up after edge E2. That is two synchronizer stages plus one register. A low `logic_on` acts at E0 itself. The bench reference keeps a three-deep history of the sampled inputs and updates its expected latch and drive state at exactly those edges. It compares both outputs at every falling system-clock edge, between the register updates. The directed latency checks sample once after E1, where the old value must still be present, and once after E2, where the new value must appear. Every link phase is held for four system clocks, so the synchronizers never miss an edge.

// File: rtl/seg_rx_pkg.sv
package seg_rx_pkg;

    localparam int SEG_N_DEF = 124;
    localparam int NIB_W_DEF = 4;

    // control lines of the link, carried together through the synchronizer
    typedef struct packed {
        logic sclk;
        logic sel_n;
        logic oe;
    } link_ctl_t;

    localparam int        CTL_W    = $bits(link_ctl_t);
    localparam link_ctl_t CTL_IDLE = '{sclk: 1'b1, sel_n: 1'b1, oe: 1'b0};

    function automatic logic fell(input logic prev, input logic now);
        return prev & ~now;
    endfunction

    function automatic logic rose(input logic prev, input logic now);
        return ~prev & now;
    endfunction

endpackage

// File: rtl/seg_sync.sv
module seg_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/seg_edge_ctrl.sv
module seg_edge_ctrl import seg_rx_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic sclk_s,
    input  logic sel_n_s,
    output logic shift_pulse,
    output logic cap_pulse
);
    logic sclk_d;
    logic sel_n_d;

    // one-cycle history of the synchronized lines, for edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= CTL_IDLE.sclk;
            sel_n_d <= CTL_IDLE.sel_n;
        end else begin
            sclk_d  <= sclk_s;
            sel_n_d <= sel_n_s;
        end
    end

    always_comb begin
        shift_pulse = active & fell(sclk_d, sclk_s) & ~sel_n_s;
        cap_pulse   = active & rose(sel_n_d, sel_n_s);
    end
endmodule

// File: rtl/seg_shift_latch.sv
module seg_shift_latch #(
    parameter int SEG_N = 124,
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_pulse,
    input  logic             cap_pulse,
    input  logic [NIB_W-1:0] nib,
    output logic [SEG_N-1:0] latched
);
    localparam int KEEP_W = SEG_N - NIB_W;

    logic [SEG_N-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg    <= '0;
            latched <= '0;
        end else begin
            if (shift_pulse)
                sreg <= {nib, sreg[SEG_N-1 -: KEEP_W]};
            if (cap_pulse)
                latched <= sreg;
        end
    end
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage #(
    parameter int SEG_N = 124
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             oe_s,
    output logic [SEG_N-1:0] drive
);
    logic drv_q;

    always_ff @(posedge clk) begin
        if (rst) drv_q <= 1'b0;
        else     drv_q <= oe_s & active;
    end

    // one flop fans out to every pad enable
    assign drive = {SEG_N{drv_q}};
endmodule

// File: rtl/seg_link_rx.sv
module seg_link_rx import seg_rx_pkg::*; #(
    parameter int SEG_N = SEG_N_DEF,
    parameter int NIB_W = NIB_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             logic_on,
    input  logic             link_sel_n,
    input  logic             link_sclk,
    input  logic [NIB_W-1:0] link_nib,
    input  logic             drv_en,
    output logic [SEG_N-1:0] seg_data,
    output logic [SEG_N-1:0] seg_drive
);
    link_ctl_t        ctl_raw;
    link_ctl_t        ctl_s;
    logic [NIB_W-1:0] nib_s;
    logic             shift_pulse;
    logic             cap_pulse;

    assign ctl_raw = '{sclk: link_sclk, sel_n: link_sel_n, oe: drv_en};

    seg_sync #(.W(CTL_W), .RST_VAL(CTL_IDLE)) u_sync_ctl (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_s)
    );

    seg_sync #(.W(NIB_W), .RST_VAL('0)) u_sync_nib (
        .clk (clk),
        .rst (rst),
        .d   (link_nib),
        .q   (nib_s)
    );

    seg_edge_ctrl u_edge (
        .clk         (clk),
        .rst         (rst),
        .active      (logic_on),
        .sclk_s      (ctl_s.sclk),
        .sel_n_s     (ctl_s.sel_n),
        .shift_pulse (shift_pulse),
        .cap_pulse   (cap_pulse)
    );

    seg_shift_latch #(.SEG_N(SEG_N), .NIB_W(NIB_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .shift_pulse (shift_pulse),
        .cap_pulse   (cap_pulse),
        .nib         (nib_s),
        .latched     (seg_data)
    );

    seg_out_stage #(.SEG_N(SEG_N)) u_out (
        .clk    (clk),
        .rst    (rst),
        .active (logic_on),
        .oe_s   (ctl_s.oe),
        .drive  (seg_drive)
    );
endmodule

// File: rtl/seg_link_rx_chk.sv
module seg_link_rx_chk #(
    parameter int SEG_N = 124
) (
    input logic             clk,
    input logic             rst,
    input logic             logic_on,
    input logic [SEG_N-1:0] seg_data,
    input logic [SEG_N-1:0] seg_drive,
    input logic             shift_pulse,
    input logic             cap_pulse
);
    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (seg_data == '0 && seg_drive == '0));

    assert_latch_only_on_release_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(seg_data) |-> $past(cap_pulse));

    assert_no_shift_at_release_R1: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |-> !cap_pulse);

    assert_standby_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        !logic_on |-> (!shift_pulse && !cap_pulse));

    assert_standby_floats_R7: assert property (@(posedge clk) disable iff (rst)
        !logic_on |=> (seg_drive == '0));

    assert_standby_holds_R7: assert property (@(posedge clk) disable iff (rst)
        !logic_on |=> $stable(seg_data));
endmodule

bind seg_link_rx seg_link_rx_chk #(.SEG_N(SEG_N)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .logic_on    (logic_on),
    .seg_data    (seg_data),
    .seg_drive   (seg_drive),
    .shift_pulse (shift_pulse),
    .cap_pulse   (cap_pulse)
);

// File: tb/seg_link_rx_tb.sv
module seg_link_rx_tb;
    localparam int N     = 124;
    localparam int NIBS  = 31;
    localparam int HOLD  = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         logic_on = 1'b1;
    logic         link_sel_n = 1'b1;
    logic         link_sclk = 1'b1;
    logic [3:0]   link_nib = 4'h0;
    logic         drv_en = 1'b0;
    logic [N-1:0] seg_data;
    logic [N-1:0] seg_drive;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seg_link_rx u_dut (
        .clk        (clk),
        .rst        (rst),
        .logic_on   (logic_on),
        .link_sel_n (link_sel_n),
        .link_sclk  (link_sclk),
        .link_nib   (link_nib),
        .drv_en     (drv_en),
        .seg_data   (seg_data),
        .seg_drive  (seg_drive)
    );

    // ---------------- reference model ----------------
    typedef struct packed {
        logic       sclk;
        logic       sel_n;
        logic       en;
        logic [3:0] nib;
    } snap_t;

    localparam snap_t IDLE = '{sclk: 1'b1, sel_n: 1'b1, en: 1'b0, nib: 4'h0};

    snap_t        h1 = IDLE, h2 = IDLE, h3 = IDLE;
    logic [N-1:0] m_sr = '0;
    logic [N-1:0] m_lat = '0;
    logic         m_drv = 1'b0;
    bit           model_live = 1'b0;

    // an input change before edge n acts at edge n+2 (R9); standby acts at once (R7)
    always @(posedge clk) begin
        if (rst) begin
            h1 = IDLE; h2 = IDLE; h3 = IDLE;
            m_sr = '0; m_lat = '0; m_drv = 1'b0;
            model_live = 1'b1;
        end else begin
            if (logic_on && h3.sclk && !h2.sclk && !h2.sel_n)
                m_sr = {h2.nib, m_sr[N-1:4]};
            else if (logic_on && !h3.sel_n && h2.sel_n)
                m_lat = m_sr;
            m_drv = h2.en && logic_on;
            h3 = h2;
            h2 = h1;
            h1 = '{sclk: link_sclk, sel_n: link_sel_n, en: drv_en, nib: link_nib};
        end
    end

    always @(negedge clk) begin
        if (!rst && model_live && !done) begin
            n_chk++;
            if (seg_data !== m_lat) begin
                n_bad++;
                $display("FAIL R4 R2 model latch act=%h exp=%h", seg_data, m_lat);
            end
            n_chk++;
            if (seg_drive !== {N{m_drv}}) begin
                n_bad++;
                $display("FAIL R6 R7 model drive act=%h exp=%h", seg_drive, {N{m_drv}});
            end
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [3:0] nib_val(input int seed, input int i);
        return 4'((seed * 7 + i * 5 + (i / 3)) & 15);
    endfunction

    function automatic logic [N-1:0] frame_bits(input int seed);
        logic [N-1:0] v = '0;
        for (int i = 0; i < NIBS; i++) v[4*i +: 4] = nib_val(seed, i);
        return v;
    endfunction

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic put_nib(input logic [3:0] v);
        link_nib = v;
        wait_cyc(HOLD);
        link_sclk = 1'b0;
        wait_cyc(HOLD);
        link_sclk = 1'b1;
        wait_cyc(HOLD);
    endtask

    task automatic send(input int seed, input int count);
        link_sel_n = 1'b0;
        wait_cyc(HOLD);
        for (int i = 0; i < count; i++) put_nib(nib_val(seed, i));
        link_sel_n = 1'b1;
        wait_cyc(2 * HOLD);
    endtask

    // ---------------- stimulus ----------------
    initial begin : main
        logic [N-1:0] prev;
        logic [N-1:0] exp_v;
        wait_cyc(5);
        chk("R8 reset latch", seg_data, '0);
        chk("R8 reset drive", seg_drive, '0);
        rst = 1'b0;
        wait_cyc(3);

        // R3 full frame; latch must not move before release (R4)
        link_sel_n = 1'b0;
        wait_cyc(HOLD);
        for (int i = 0; i < NIBS; i++) put_nib(nib_val(3, i));
        chk("R4 latch before release", seg_data, '0);
        link_sel_n = 1'b1;
        wait_cyc(2 * HOLD);
        chk("R3 full frame order", seg_data, frame_bits(3));

        // R9 enable latency, R6 drive
        drv_en = 1'b1;
        wait_cyc(2);
        chk("R9 drive still off after two edges", seg_drive, '0);
        wait_cyc(1);
        chk("R9 R6 drive on at third edge", seg_drive, {N{1'b1}});

        // R5 partial transfer of 3 nibbles
        prev = seg_data;
        send(9, 3);
        exp_v = {nib_val(9, 2), nib_val(9, 1), nib_val(9, 0), prev[N-1:12]};
        chk("R5 R2 partial update", seg_data, exp_v);

        // R1 clock edges with select high are ignored
        prev = seg_data;
        for (int i = 0; i < 5; i++) put_nib(4'hF);
        send(0, 0);
        chk("R1 clocks with select high ignored", seg_data, prev);

        // R6 enable low floats all pins
        drv_en = 1'b0;
        wait_cyc(3);
        chk("R6 drive off", seg_drive, '0);
        drv_en = 1'b1;
        wait_cyc(3);
        chk("R6 drive back on", seg_drive, {N{1'b1}});

        // R7 standby
        prev = seg_data;
        logic_on = 1'b0;
        wait_cyc(1);
        chk("R7 standby floats at first edge", seg_drive, '0);
        send(11, NIBS);
        chk("R7 standby blocks latch", seg_data, prev);
        logic_on = 1'b1;
        send(0, 0);
        chk("R7 standby blocked shifting", seg_data, prev);
        chk("R7 drive resumes", seg_drive, {N{1'b1}});

        // R3 second full frame with another pattern
        send(5, NIBS);
        chk("R3 second full frame", seg_data, frame_bits(5));
        wait_cyc(2);
        done = 1'b1;
    end

    initial begin : watchdog
        while (!done && cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=done", cycles);
            done = 1'b1;
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule